// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while acting as the clock master of a two-wire synchronous link. It divides the system clock down to a bit clock, drives that clock out on its clock pin, and captures one data bit on each falling edge. Bits arrive least significant first. A word is 8 bits, or 9 bits when the ninth-bit option is on. The ninth bit goes to the status register and the low eight bits go to the data register.

Software sets up the block through a small four-register bus. It picks the divisor, selects synchronous operation and the clock-source role, and then arms reception. Reception comes in two forms. The single-shot form takes one word and then disarms itself. The continuous form keeps taking words until software disarms it. A ready flag, with an optional interrupt, reports each finished word. If a word finishes while the previous one is still unread, the block discards the new word, sets an overrun flag and halts the link. Only disarming continuous reception removes that flag.

Top module: `sync_master_rx`

## Requirements
- R1: The bit clock runs only when all of these hold: port enable (status bit 7) is set, the synchronous-mode bit (mode register, address 3, bit 0) is set, the clock-source bit (mode bit 1) is set, and at least one receive enable is set. Otherwise no clock edge appears.
- R2: One data bit is captured on each falling edge of the output clock. The first bit captured becomes bit 0 of the word.
- R3: With only the single-shot enable set (status bit 5), the block receives exactly one word. It then clears bit 5 by itself, and the clock stays low afterwards.
- R4: With the continuous enable set (status bit 4), the block receives words back to back until bit 4 is written to 0.
- R5: When both enables are set, the continuous behaviour governs, so reception carries on past the first word.
- R6: When the ninth-bit option (status bit 6) is set, each word has 9 bits. The ninth bit received appears in status bit 0, and the first eight bits appear in the data register (address 1).
- R7: A finished word sets the ready output. The interrupt output equals ready while the interrupt enable (mode bit 2) is set, and stays low while that enable is clear.
- R8: Reading the data register clears the ready flag and the interrupt.
- R9: The status register is at address 0. Its bits are: 7 port enable, 6 ninth-bit option, 5 single-shot enable, 4 continuous enable, 3 address-detect enable (stored only), 2 framing error (always 0), 1 overrun, 0 ninth data bit. After reset, bits 7 to 1 read 0.
- R10: The divisor register is at address 2. The output clock period is 4 × (divisor + 1) system clocks.
- R11: When a word finishes while ready is still set, the overrun bit is set and the data register keeps its old value. The clock then stops for as long as overrun stays set.
- R12: The overrun bit clears only on a status write that has bit 4 equal to 0.
- R13: While reception is not running, the clock output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on the data register) |
| bus_addr | input | 2 | Register address: 0 status, 1 data, 2 divisor, 3 mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sdata_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Bit clock driven to the slave |
| rx_ready_o | output | 1 | A received word is waiting |
| irq_o | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is overrun. A second word has to finish while the first is still unread, and then the bench must confirm that the clock has stopped and that the old data survived. The bench arms continuous reception with a slave model that has two words loaded. It deliberately does not read the data register and polls the status register until the overrun bit appears. It then reads the data, counts falling edges over a quiet window, and finally disarms continuous mode to show that the flag clears.

// File: rtl/smrx_pkg.sv
// Package: shared register addresses, status bit positions and word type
// for the synchronous master receiver.
package smrx_pkg;
    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_DATA = 2'd1,
        REG_DIV  = 2'd2,
        REG_MODE = 2'd3
    } reg_addr_e;

    // Status register bit positions (software decodes these).
    localparam int ST_PORT   = 7;
    localparam int ST_NINE   = 6;
    localparam int ST_SINGLE = 5;
    localparam int ST_CONT   = 4;
    localparam int ST_ADR    = 3;
    localparam int ST_FRAME  = 2;
    localparam int ST_OVR    = 1;
    localparam int ST_BIT9   = 0;

    // Mode register bit positions.
    localparam int MD_SYNC   = 0;
    localparam int MD_MASTER = 1;
    localparam int MD_IE     = 2;
endpackage

// File: rtl/smrx_sync.sv
// Module: smrx_sync
// Brings the asynchronous serial data pin into the clk domain through a
// chain of flip-flops. Assumes STAGES >= 2.
module smrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the pin value one stage further each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/smrx_clkgen.sv
// Module: smrx_clkgen
// Generates the bit clock. Each clock half lasts 2*(div+1) system clocks,
// so a full period lasts 4*(div+1). The clock starts and idles low, and
// the counter restarts whenever run is low. fall_stb is high in the cycle
// whose edge drives the clock from high to low.
module smrx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             fall_stb
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic             term;

    assign term     = (cnt == {div, 1'b1});
    assign fall_stb = run & term & sclk;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (term) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smrx_shifter.sv
// Module: smrx_shifter
// Shifts in one bit on each clock falling edge, least significant bit
// first, and emits a one-cycle done pulse with the assembled word. For
// 8-bit words, word[8] is 0. The bit counter restarts while run is low.
module smrx_shifter
    import smrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  nine,
    input  logic  fall_stb,
    input  logic  sdata,
    output logic  done,
    output word_t word
);
    logic [3:0] bitcnt;
    word_t      shreg;
    word_t      shift_nx;
    logic       last;

    assign shift_nx = {sdata, shreg[WORD_W-1:1]};
    assign last     = (bitcnt == (nine ? 4'd8 : 4'd7));

    // Bit capture, bit count and word completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            done   <= 1'b0;
            word   <= '0;
        end else if (!run) begin
            bitcnt <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (fall_stb) begin
                shreg <= shift_nx;
                if (last) begin
                    bitcnt <= '0;
                    done   <= 1'b1;
                    word   <= nine ? shift_nx : {1'b0, shift_nx[WORD_W-1:1]};
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/smrx_regs.sv
// Module: smrx_regs
// Register file: status/control, data, divisor and mode. Arbitrates the
// single-shot and continuous enables, keeps the ready and overrun flags,
// and produces the run condition for the clock generator.
module smrx_regs
    import smrx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             done,
    input  word_t            word,
    output logic             run,
    output logic [DIV_W-1:0] div,
    output logic             nine_en,
    output logic             single_en,
    output logic             cont_en,
    output logic             ready,
    output logic             ovr,
    output logic [7:0]       data_q,
    output logic             irq
);
    logic port_en, adr_en, bit9;
    logic sync_en, master_en, ie;
    logic wr_stat, rd_data, ovr_clr, ovr_set;

    assign wr_stat = bus_wr && (bus_addr == REG_STAT);
    assign rd_data = bus_rd && (bus_addr == REG_DATA);
    assign ovr_clr = wr_stat && !bus_wdata[ST_CONT];
    assign ovr_set = done && ready && !rd_data;

    assign run = port_en & sync_en & master_en & (single_en | cont_en) & ~ovr;
    assign irq = ready & ie;

    // Enable bits: software writes, plus the single-shot self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en   <= 1'b0;
            nine_en   <= 1'b0;
            single_en <= 1'b0;
            cont_en   <= 1'b0;
            adr_en    <= 1'b0;
        end else if (wr_stat) begin
            port_en   <= bus_wdata[ST_PORT];
            nine_en   <= bus_wdata[ST_NINE];
            single_en <= bus_wdata[ST_SINGLE];
            cont_en   <= bus_wdata[ST_CONT];
            adr_en    <= bus_wdata[ST_ADR];
        end else if (done && !cont_en) begin
            single_en <= 1'b0;
        end
    end

    // Mode and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_en   <= 1'b0;
            master_en <= 1'b0;
            ie        <= 1'b0;
            div       <= '0;
        end else if (bus_wr) begin
            if (bus_addr == REG_MODE) begin
                sync_en   <= bus_wdata[MD_SYNC];
                master_en <= bus_wdata[MD_MASTER];
                ie        <= bus_wdata[MD_IE];
            end
            if (bus_addr == REG_DIV) div <= bus_wdata[DIV_W-1:0];
        end
    end

    // Received data, ninth bit and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            bit9   <= 1'b0;
            ready  <= 1'b0;
        end else if (done && !ovr_set) begin
            data_q <= word[7:0];
            bit9   <= word[WORD_W-1];
            ready  <= 1'b1;
        end else if (rd_data) begin
            ready  <= 1'b0;
        end
    end

    // Overrun flag: set on a word that finds the previous one unread.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (ovr_clr) ovr <= 1'b0;
        else if (ovr_set) ovr <= 1'b1;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_STAT: bus_rdata = {port_en, nine_en, single_en, cont_en,
                                   adr_en, 1'b0, ovr, bit9};
            REG_DATA: bus_rdata = data_q;
            REG_DIV:  bus_rdata[DIV_W-1:0] = div;
            default:  bus_rdata = {5'b0, ie, master_en, sync_en};
        endcase
    end
endmodule

// File: rtl/sync_master_rx.sv
// Module: sync_master_rx
// Top of the synchronous master receiver. It wires the register file, the
// clock generator, the data synchronizer and the shifter together.
// Assumes the slave changes data after the rising clock edge, with at
// least two system clocks of set-up before the falling edge.
module sync_master_rx
    import smrx_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sdata_i,
    output logic       sclk_o,
    output logic       rx_ready_o,
    output logic       irq_o
);
    logic             run, fall_stb, sdata_s, word_done;
    logic             nine_en, single_en, cont_en, ready, ovr;
    logic [DIV_W-1:0] div;
    logic [7:0]       data_q;
    word_t            word;

    smrx_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(word_done), .word(word),
        .run(run), .div(div), .nine_en(nine_en),
        .single_en(single_en), .cont_en(cont_en),
        .ready(ready), .ovr(ovr), .data_q(data_q), .irq(irq_o)
    );

    smrx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div),
        .sclk(sclk_o), .fall_stb(fall_stb)
    );

    smrx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sdata_i), .q_o(sdata_s)
    );

    smrx_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .run(run), .nine(nine_en),
        .fall_stb(fall_stb), .sdata(sdata_s),
        .done(word_done), .word(word)
    );

    assign rx_ready_o = ready;
endmodule

// File: rtl/smrx_checker.sv
// Module: smrx_checker
// Temporal properties of the receiver, bound into sync_master_rx.
module smrx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       sclk,
    input logic       done,
    input logic       ready,
    input logic       ovr,
    input logic       single_en,
    input logic       cont_en,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] data_q
);
    logic stat_wr;
    assign stat_wr = bus_wr && (bus_addr == 2'd0);

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk); // R13
    AST_READY_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(done)); // R7
    AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && single_en && !cont_en && !stat_wr) |=> !single_en); // R3
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(stat_wr && !bus_wdata[4])) |=> ovr); // R12
    AST_OVR_BLOCKS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> !sclk); // R11
    AST_DATA_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(data_q)); // R11
endmodule

bind sync_master_rx smrx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk_o), .done(word_done),
    .ready(ready), .ovr(ovr), .single_en(single_en), .cont_en(cont_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .data_q(data_q)
);

// File: tb/tb_sync_master_rx.sv
// Directed bench for sync_master_rx. A slave model drives a new bit after
// each rising clock edge, and one task per scenario checks its results.
module tb_sync_master_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sdata_i = 1'b0;
    logic       sclk_o, rx_ready_o, irq_o;

    int checks = 0, errors = 0;
    logic [8:0] words [4];
    int widx = 0, bidx = 0, nbits = 8;
    int fall_cnt = 0, cyc = 0, last_rise = 0, rise_period = 0;
    logic prev_sclk = 1'b0;

    always #5 clk = ~clk;

    sync_master_rx dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sdata_i(sdata_i), .sclk_o(sclk_o), .rx_ready_o(rx_ready_o),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic load(input logic [8:0] w0, w1, w2, input int nb);
        words[0] = w0; words[1] = w1; words[2] = w2; words[3] = '0;
        widx = 0; bidx = 0; nbits = nb; fall_cnt = 0;
    endtask

    task automatic wait_ready(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rx_ready_o) begin ok = 1'b1; break; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Slave model and edge monitor, sampled away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (sclk_o && !prev_sclk) begin
                rise_period = cyc - last_rise;
                last_rise = cyc;
                sdata_i = words[widx][bidx];
                bidx++;
                if (bidx == nbits) begin
                    bidx = 0;
                    if (widx < 3) widx++;
                end
            end
            if (!sclk_o && prev_sclk) fall_cnt++;
            prev_sclk = sclk_o;
        end
    end

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd0, d);
        check("R9 status reset", d & 8'hFE, 0);
        check("R13 clock low at reset", sclk_o, 0);
        check("R7 ready at reset", rx_ready_o, 0);
        check("R7 irq at reset", irq_o, 0);
    endtask

    task automatic t_gating;
        load(9'h0F0, 0, 0, 8);
        wr(2'd2, 8'd1);
        wr(2'd3, 8'h01);            // sync only, not clock source
        wr(2'd0, 8'hA0);
        idle(80);
        check("R1 no clock without clock source", fall_cnt, 0);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h20);            // port disabled
        idle(80);
        check("R1 no clock without port enable", fall_cnt, 0);
        check("R13 clock idle low", sclk_o, 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_single;
        logic [7:0] d; bit ok;
        load(9'h0A5, 9'h0FF, 0, 8);
        wr(2'd3, 8'h07);
        wr(2'd2, 8'd1);
        wr(2'd0, 8'hA0);
        wait_ready(ok);
        check("R7 ready after word", ok, 1);
        check("R7 irq follows ready", irq_o, 1);
        idle(60);
        check("R3 single word only: falling edges", fall_cnt, 8);
        check("R3 clock stopped low", sclk_o, 0);
        rd(2'd0, d);
        check("R3 single enable self-cleared", d[5], 0);
        rd(2'd1, d);
        check("R2 data LSB first", d, 8'hA5);
        check("R8 read clears ready", rx_ready_o, 0);
        check("R8 read clears irq", irq_o, 0);
    endtask

    task automatic t_period;
        logic [7:0] d; bit ok;
        load(9'h03C, 0, 0, 8);
        wr(2'd3, 8'h03);            // interrupt enable off
        wr(2'd2, 8'd2);
        wr(2'd0, 8'hA0);
        wait_ready(ok);
        check("R10 period for divisor 2", rise_period, 12);
        check("R7 irq masked when enable clear", irq_o, 0);
        rd(2'd1, d);
        check("R2 data for divisor 2", d, 8'h3C);
        wr(2'd2, 8'd1);
    endtask

    task automatic t_nine;
        logic [7:0] d; bit ok;
        load(9'h13C, 0, 0, 9);
        wr(2'd0, 8'hE0);
        wait_ready(ok);
        idle(40);
        check("R6 nine falling edges", fall_cnt, 9);
        rd(2'd0, d);
        check("R6 ninth bit set", d[0], 1);
        rd(2'd1, d);
        check("R6 low byte", d, 8'h3C);
        load(9'h0C3, 0, 0, 9);
        wr(2'd0, 8'hE0);
        wait_ready(ok);
        rd(2'd0, d);
        check("R6 ninth bit clear", d[0], 0);
        rd(2'd1, d);
        check("R6 low byte second word", d, 8'hC3);
    endtask

    task automatic t_cont(input logic [7:0] ctl, input string req);
        logic [7:0] d; bit ok;
        logic [7:0] exp [3] = '{8'h11, 8'h22, 8'h33};
        load(9'h011, 9'h022, 9'h033, 8);
        wr(2'd0, ctl);
        for (int i = 0; i < 3; i++) begin
            wait_ready(ok);
            check({req, " word arrives"}, ok, 1);
            rd(2'd1, d);
            check({req, " word value"}, d, exp[i]);
        end
        wr(2'd0, 8'h80);
        idle(4);
        fall_cnt = 0;
        idle(80);
        check("R4 clearing continuous stops clock", fall_cnt, 0);
        check("R13 clock low after stop", sclk_o, 0);
        if (rx_ready_o) rd(2'd1, d);
    endtask

    task automatic t_overrun;
        logic [7:0] d; bit ok;
        load(9'h05A, 9'h077, 9'h0EE, 8);
        wr(2'd0, 8'h90);
        ok = 1'b0;
        for (int i = 0; i < 300; i++) begin
            rd(2'd0, d);
            if (d[1]) begin ok = 1'b1; break; end
        end
        check("R11 overrun flag set", ok, 1);
        fall_cnt = 0;
        idle(80);
        check("R11 clock halted under overrun", fall_cnt, 0);
        wr(2'd1, 8'h00);            // writes to data are ignored
        rd(2'd1, d);
        check("R11 old word kept", d, 8'h5A);
        rd(2'd0, d);
        check("R12 overrun survives data read", d[1], 1);
        wr(2'd0, 8'h80);
        rd(2'd0, d);
        check("R12 clearing continuous clears overrun", d[1], 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_gating();
        t_single();
        t_period();
        t_nine();
        wr(2'd2, 8'd1);
        t_cont(8'h90, "R4");
        t_cont(8'hB0, "R5");
        t_overrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule